// File: doc/BRIEF.md
# JTAG Two-Scan Register Access Client

This block sits behind a JTAG TAP controller and lets an external debug tool read and write a small bank of internal registers. It does not contain the TAP state machine or the instruction decode; it receives the TAP's capture-DR, shift-DR and update-DR decodes, the TDI bit, and a flag that says its own instruction is loaded. It drives TDO back.

Every access is a pair of data-register scans. The first scan is an 8-bit command that carries a 7-bit register index and a direction bit. The second scan is 32 bits long and moves the register data. In a write, the new value goes in and the old value comes out on TDO. In a read, the value comes out on TDO and the bits shifted in are discarded.

The block also builds one reset for the downstream debug logic. That reset combines power-on reset, the JTAG compliance input and a censor input, so the downstream modules never have to look at those three inputs themselves.

Top module: `jtag_reg_client`

## Requirements
- R1: A command scan is 8 bits, shifted LSB first. Bit 0 is the direction bit (1 = write, 0 = read) and bits 7:1 hold the register index. Each update-DR while the client is active switches between command phase and data phase.
- R2: When the direction bit is 1, the 32-bit data scan (shifted LSB first) is written into the selected register at update-DR.
- R3: During a write data scan, TDO carries the register's previous contents, LSB first.
- R4: When the direction bit is 0, TDO carries the selected register's value. The bits shifted in are discarded, so a later read returns the same value.
- R5: While `instr_sel` is low, scans do not change any register and TDO stays 0. Dropping `instr_sel` returns the client to command phase.
- R6: `dbg_rst` goes high at once, with no clock edge needed, when `por_rst` is 1, `jtag_comp` is 0 or `censor` is 1. Once all three conditions clear, it goes low on the second rising TCK edge.
- R7: Index 0 reads the constant ID_VALUE (default 32'h1A5E0C31). Index 2 reads `status_i` as sampled at capture-DR. Writes to both are ignored.
- R8: Index 1 is the control register and is driven on `ctrl_o`. Indices 3 to 6 are scratch registers. All of these are read/write and read back what was last written.
- R9: An index with no register (7 to 127) reads as zero, and writing to it changes no register.
- R10: While `dbg_rst` is high, the read/write registers clear to zero and the client returns to command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_rst | input | 1 | Power-on reset, active high |
| jtag_comp | input | 1 | JTAG compliance enable; 0 holds debug logic in reset |
| censor | input | 1 | Censored-device flag; 1 holds debug logic in reset |
| instr_sel | input | 1 | The client's enable instruction is loaded in the TAP |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| status_i | input | 32 | Live status value, read through index 2 |
| tdo | output | 1 | Serial data out |
| dbg_rst | output | 1 | Combined reset for the downstream debug modules |
| ctrl_o | output | 32 | Contents of the control register |

## Verification
Random transactions mix reads and writes over implemented, read-only and empty indices. Comparing the TDO stream of each write with the value previously stored in the model separates an old-value return from a new-value echo. Directed cases do the following:
- Read back a register after a read that shifted in junk, which shows the discarded data really is discarded.
- Scan with the instruction deselected, which shows the client is inert when not selected.
- Drop the instruction in the middle of a transaction, which shows the client resynchronises to command phase.
- Raise each reset source in turn, which separates immediate assertion of `dbg_rst` from its two-edge release.

// File: rtl/jcl_pkg.sv
package jcl_pkg;
  localparam int CMD_W = 8;
  localparam int IDX_W = CMD_W - 1;

  // Command word: direction in bit 0, index above it.
  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wr;
  } cmd_t;
endpackage

// File: rtl/jcl_reset_gen.sv
module jcl_reset_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic por_rst,
  input  logic jtag_comp,
  input  logic censor,
  output logic dbg_rst
);
  logic raw_rst;
  logic [SYNC_STAGES-1:0] chain_q;

  assign raw_rst = por_rst | ~jtag_comp | censor;

  // Set immediately, cleared one stage per TCK edge.
  always_ff @(posedge tck or posedge raw_rst) begin
    if (raw_rst) chain_q <= '1;
    else         chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b0};
  end

  assign dbg_rst = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/jcl_scan_path.sv
module jcl_scan_path
  import jcl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              active,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_val,
  output logic              tdo,
  output logic              data_phase,
  output cmd_t              cmd,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PAD_W = DATA_W - CMD_W;

  logic [DATA_W-1:0] sr_q;
  logic              phase_q;
  cmd_t              cmd_q;

  always_ff @(posedge tck) begin
    if (rst || !active) begin
      sr_q    <= '0;
      phase_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      if (capture_dr) begin
        sr_q <= phase_q ? cap_val : '0;
      end else if (shift_dr) begin
        if (phase_q) sr_q <= {tdi, sr_q[DATA_W-1:1]};
        else         sr_q <= {{PAD_W{1'b0}}, tdi, sr_q[CMD_W-1:1]};
      end
      if (update_dr) begin
        phase_q <= ~phase_q;
        if (!phase_q) cmd_q <= cmd_t'(sr_q[CMD_W-1:0]);
      end
    end
  end

  assign tdo        = sr_q[0];
  assign data_phase = phase_q;
  assign cmd        = cmd_q;
  assign wr_en      = active & update_dr & phase_q & cmd_q.wr;
  assign wr_data    = sr_q;
endmodule

// File: rtl/jcl_reg_bank.sv
module jcl_reg_bank #(
  parameter int          DATA_W       = 32,
  parameter int          IDX_W        = 7,
  parameter logic [31:0] ID_VALUE     = 32'h1A5E_0C31,
  parameter int          ID_IDX       = 0,
  parameter int          CTRL_IDX     = 1,
  parameter int          STAT_IDX     = 2,
  parameter int          SCR_BASE     = 3,
  parameter int          NUM_SCRATCH  = 4
) (
  input  logic              tck,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] scr_q [NUM_SCRATCH];

  always_ff @(posedge tck) begin
    if (rst)                                        ctrl_q <= '0;
    else if (wr_en && wr_idx == IDX_W'(CTRL_IDX))   ctrl_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
    always_ff @(posedge tck) begin
      if (rst)                                          scr_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(SCR_BASE + g)) scr_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_W'(ID_IDX))   rd_data = DATA_W'(ID_VALUE);
    if (rd_idx == IDX_W'(CTRL_IDX)) rd_data = ctrl_q;
    if (rd_idx == IDX_W'(STAT_IDX)) rd_data = status_i;
    for (int i = 0; i < NUM_SCRATCH; i++)
      if (rd_idx == IDX_W'(SCR_BASE + i)) rd_data = scr_q[i];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/jtag_reg_client.sv
module jtag_reg_client
  import jcl_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] ID_VALUE    = 32'h1A5E_0C31,
  parameter int          NUM_SCRATCH = 4
) (
  input  logic              tck,
  input  logic              por_rst,
  input  logic              jtag_comp,
  input  logic              censor,
  input  logic              instr_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] status_i,
  output logic              tdo,
  output logic              dbg_rst,
  output logic [DATA_W-1:0] ctrl_o
);
  logic              active;
  logic              data_phase;
  cmd_t              cmd;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  jcl_reset_gen #(.SYNC_STAGES(2)) u_rst (
    .tck(tck), .por_rst(por_rst), .jtag_comp(jtag_comp),
    .censor(censor), .dbg_rst(dbg_rst)
  );

  assign active = ~dbg_rst & instr_sel;

  jcl_scan_path #(.DATA_W(DATA_W)) u_scan (
    .tck(tck), .rst(dbg_rst), .active(active),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .cap_val(rd_data), .tdo(tdo), .data_phase(data_phase),
    .cmd(cmd), .wr_en(wr_en), .wr_data(wr_data)
  );

  jcl_reg_bank #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ID_VALUE(ID_VALUE),
    .NUM_SCRATCH(NUM_SCRATCH)
  ) u_bank (
    .tck(tck), .rst(dbg_rst), .rd_idx(cmd.idx), .wr_en(wr_en),
    .wr_idx(cmd.idx), .wr_data(wr_data), .status_i(status_i),
    .rd_data(rd_data), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/jcl_checker.sv
module jcl_checker #(
  parameter int DATA_W = 32
) (
  input logic              tck,
  input logic              por_rst,
  input logic              jtag_comp,
  input logic              censor,
  input logic              instr_sel,
  input logic              update_dr,
  input logic              tdo,
  input logic              dbg_rst,
  input logic              data_phase,
  input logic [DATA_W-1:0] ctrl_o
);
  assert_rst_follows_R6: assert property (@(posedge tck) disable iff (por_rst)
    (!jtag_comp || censor) |-> dbg_rst);

  assert_quiet_tdo_R5: assert property (@(posedge tck) disable iff (dbg_rst)
    !instr_sel |=> !tdo);

  assert_cmd_phase_R5: assert property (@(posedge tck) disable iff (dbg_rst)
    !instr_sel |=> !data_phase);

  assert_ctrl_frozen_R5: assert property (@(posedge tck) disable iff (dbg_rst)
    !instr_sel |=> $stable(ctrl_o));

  assert_ctrl_on_update_R2: assert property (@(posedge tck) disable iff (dbg_rst)
    !update_dr |=> $stable(ctrl_o));

  assert_rst_clears_R10: assert property (@(posedge tck) disable iff (por_rst)
    dbg_rst |=> (ctrl_o == '0 && !data_phase));
endmodule

bind jtag_reg_client jcl_checker #(.DATA_W(DATA_W)) u_chk (
  .tck(tck), .por_rst(por_rst), .jtag_comp(jtag_comp), .censor(censor),
  .instr_sel(instr_sel), .update_dr(update_dr), .tdo(tdo),
  .dbg_rst(dbg_rst), .data_phase(data_phase), .ctrl_o(ctrl_o)
);

// File: tb/tb_jtag_reg_client.sv
module tb_jtag_reg_client;
  localparam logic [31:0] ID = 32'h1A5E_0C31;

  logic tck = 0, por_rst = 1, jtag_comp = 0, censor = 0, instr_sel = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [31:0] status_i = 32'h0;
  logic tdo, dbg_rst;
  logic [31:0] ctrl_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [0:127];
  logic [31:0] got;
  logic [31:0] dummy;

  jtag_reg_client dut (.*);

  always #5 tck = ~tck;

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_rw(int idx);
    return idx == 1 || (idx >= 3 && idx <= 6);
  endfunction

  function automatic logic [31:0] exp_val(int idx);
    if (idx == 0) return ID;
    if (idx == 2) return status_i;
    if (is_rw(idx)) return model[idx];
    return 32'h0;
  endfunction

  // One DR scan: capture, n shift cycles, update. Inputs change at negedge.
  task automatic scan(int n, logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    capture_dr = 1; @(negedge tck); capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = din[i];
      dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; tdi = 0;
    update_dr = 1; @(negedge tck); update_dr = 0;
    @(negedge tck);
  endtask

  task automatic access(int idx, bit wr, logic [31:0] data, output logic [31:0] old);
    logic [31:0] c;
    scan(8, {24'h0, idx[6:0], wr}, c);
    scan(32, data, old);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    @(negedge tck); @(negedge tck);
    check("R6 reset held", {31'h0, dbg_rst}, 32'h1);
    por_rst = 0; jtag_comp = 1;
    @(negedge tck);
    check("R6 release not yet", {31'h0, dbg_rst}, 32'h1);
    @(negedge tck);
    check("R6 released", {31'h0, dbg_rst}, 32'h0);
    check("R10 ctrl reset", ctrl_o, 32'h0);
    instr_sel = 1;

    // Directed: ID read, R7
    access(0, 0, 32'hFFFF_FFFF, got);
    check("R7 id read", got, ID);
    access(0, 1, 32'h1234_5678, got);
    access(0, 0, 32'h0, got);
    check("R7 id unwritable", got, ID);

    // R2/R3/R8 ctrl write
    access(1, 1, 32'hCAFE_F00D, got);
    check("R3 old value", got, 32'h0);
    check("R8 ctrl_o", ctrl_o, 32'hCAFE_F00D);
    model[1] = 32'hCAFE_F00D;

    // R4 read discards shifted data
    access(1, 0, 32'h5555_AAAA, got);
    check("R4 read", got, 32'hCAFE_F00D);
    access(1, 0, 32'h0, got);
    check("R4 unchanged", got, 32'hCAFE_F00D);
    check("R4 ctrl_o kept", ctrl_o, 32'hCAFE_F00D);

    // R1 bit ordering: index 5 = command 8'b0000_1011
    access(5, 1, 32'h0BAD_BEEF, got);
    model[5] = 32'h0BAD_BEEF;
    access(5, 0, 32'h0, got);
    check("R1 index/direction layout", got, 32'h0BAD_BEEF);

    // R9 unimplemented
    access(100, 1, 32'hDEAD_DEAD, got);
    check("R9 empty write old", got, 32'h0);
    access(100, 0, 32'h0, got);
    check("R9 empty read", got, 32'h0);
    access(127, 0, 32'h0, got);
    check("R9 top index", got, 32'h0);

    // R7 status
    status_i = 32'h7E57_0001;
    access(2, 1, 32'h0, got);
    check("R7 status old", got, 32'h7E57_0001);
    access(2, 0, 32'h0, got);
    check("R7 status read", got, 32'h7E57_0001);

    // R5 disabled scans
    instr_sel = 0;
    begin
      logic [31:0] c;
      scan(8, 32'h03, c);
      check("R5 tdo quiet cmd", c, 32'h0);
      scan(32, 32'h1111_2222, c);
      check("R5 tdo quiet data", c, 32'h0);
    end
    check("R5 ctrl unchanged", ctrl_o, 32'hCAFE_F00D);
    instr_sel = 1;
    access(1, 0, 32'h0, got);
    check("R5 ctrl readback", got, 32'hCAFE_F00D);

    // R5 resync: half transaction then deselect
    scan(8, 32'h07, dummy);       // write cmd to index 3
    instr_sel = 0; @(negedge tck); instr_sel = 1;
    access(1, 0, 32'h0, got);
    check("R5 resync to command", got, 32'hCAFE_F00D);
    access(3, 0, 32'h0, got);
    check("R5 aborted write", got, 32'h0);

    // Random mix
    for (int k = 0; k < 300; k++) begin
      int idx;
      bit wr;
      logic [31:0] d, e;
      idx = (k % 7 == 0) ? int'($urandom % 128) : int'($urandom % 10);
      wr = $urandom % 2;
      d = $urandom;
      status_i = $urandom;
      e = exp_val(idx);
      access(idx, wr, d, got);
      check(wr ? "R3 random write" : "R4 random read", got, e);
      if (wr && is_rw(idx)) model[idx] = d;
      check("R8 random ctrl_o", ctrl_o, model[1]);
    end

    // R6 each source, R10 clear
    censor = 1; #1;
    check("R6 censor async", {31'h0, dbg_rst}, 32'h1);
    @(negedge tck); censor = 0;
    @(negedge tck); @(negedge tck);
    check("R10 ctrl cleared", ctrl_o, 32'h0);
    jtag_comp = 0; #1;
    check("R6 comp async", {31'h0, dbg_rst}, 32'h1);
    @(negedge tck); jtag_comp = 1;
    por_rst = 1; #1;
    check("R6 por async", {31'h0, dbg_rst}, 32'h1);
    @(negedge tck); por_rst = 0;
    @(negedge tck); @(negedge tck);
    check("R6 released again", {31'h0, dbg_rst}, 32'h0);
    access(5, 0, 32'h0, got);
    check("R10 scratch cleared", got, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule